// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block is the combinational address selector that sits after decode in a simple 32-bit load/store processor. It takes the current program counter, the values of the two source registers, a 16-bit branch offset field, a 26-bit jump target field and a 3-bit operation select. From these it returns the address of the next instruction to fetch.

It also returns a link-write request and the link value for the register file. All forming rules use the address of the following instruction (PC+4) as their base. Branches are word-scaled and PC-relative. Jumps keep the current 256 MB region. Register jumps take the register value verbatim.

Delay slots, exceptions and the fetch stage lie outside this block.

Select encoding: 0 sequential, 1 branch-if-equal, 2 branch-if-not-equal, 3 jump, 4 jump-register, 5 jump-and-link, 6 branch-and-link (unconditional), 7 reserved.

Top module: `nextpc_unit`

## Requirements
- R1: With select 0 (sequential) or the reserved code 7, next_pc_o is pc_i+4 and link_we_o is 0.
- R2: With select 1, next_pc_o is pc_i+4+(sign-extended offset times 4) when rs_val_i equals rt_val_i, and pc_i+4 otherwise.
- R3: With select 2, the branch is taken when rs_val_i differs from rt_val_i, and next_pc_o is pc_i+4 when they are equal.
- R4: The branch offset is treated as a signed 16-bit word count: bit 15 set moves the target backwards, and all address sums wrap modulo 2^32.
- R5: With select 3, next_pc_o is {(pc_i+4)[31:28], jmp_tgt_i, 2'b00}. The region bits come from pc_i+4, not from pc_i.
- R6: With select 4, next_pc_o equals rs_val_i exactly, including bits [1:0].
- R7: With select 5, next_pc_o is formed as in R5, link_we_o is 1 and link_val_o is pc_i+4.
- R8: With select 6, the branch target of R2 is always taken, link_we_o is 1 and link_val_o is pc_i+4.
- R9: link_we_o is 1 only for selects 5 and 6, and link_val_o is always pc_i+4.
- R10: When pc_i[1:0] is 0, next_pc_o[1:0] is 0 for every select except 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Current program counter |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| br_ofs_i | input | 16 | Signed branch offset in words |
| jmp_tgt_i | input | 26 | Jump target field in words |
| sel_i | input | 3 | Operation select (encoding above) |
| next_pc_o | output | 32 | Address of next instruction |
| link_we_o | output | 1 | Link register write request |
| link_val_o | output | 32 | Value to write as link |

## Verification
The bench goes after the region edge at PC 0x0FFFFFFC. A design that took the region bits from pc_i instead of pc_i+4 would jump into the wrong 256 MB region there. It drives the extreme offsets 0x7FFF and 0x8000 and a PC near the top of memory. A zero-extended offset or a missing wrap would land far from the true target. Equal and unequal operand pairs are both forced for every branch form, so a swapped condition shows up. Unaligned register values check that jump-register does not mask the low bits, and every select is checked for a stray link write.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  typedef enum logic [2:0] {
    NPC_SEQ  = 3'd0,
    NPC_BEQ  = 3'd1,
    NPC_BNE  = 3'd2,
    NPC_JMP  = 3'd3,
    NPC_JREG = 3'd4,
    NPC_JAL  = 3'd5,
    NPC_BAL  = 3'd6,
    NPC_RSVD = 3'd7
  } npc_sel_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] pc_next_seq
);
  function automatic logic [XLEN-1:0] f_step(input logic [XLEN-1:0] a);
    return a + XLEN'(STEP);
  endfunction

  assign pc_next_seq = f_step(pc);
endmodule

// File: rtl/npc_branch.sv
module npc_branch #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16
) (
  input  logic [XLEN-1:0]  base,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  input  logic [OFS_W-1:0] ofs,
  input  logic             want_eq,
  input  logic             want_ne,
  input  logic             always_go,
  output logic             taken,
  output logic [XLEN-1:0]  target
);
  localparam int EXT_W = XLEN - OFS_W - 2;

  function automatic logic [XLEN-1:0] f_scale(input logic [OFS_W-1:0] o);
    return {{EXT_W{o[OFS_W-1]}}, o, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] f_rel(input logic [XLEN-1:0] b,
                                            input logic [OFS_W-1:0] o);
    return b + f_scale(o);
  endfunction

  logic same;
  assign same   = (opa == opb);
  assign taken  = always_go | (want_eq & same) | (want_ne & ~same);
  assign target = f_rel(base, ofs);
endmodule

// File: rtl/npc_region.sv
module npc_region #(
  parameter int XLEN  = 32,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-1:0]  base,
  input  logic [TGT_W-1:0] tgt,
  output logic [XLEN-1:0]  target
);
  localparam int REG_W = XLEN - TGT_W - 2;

  function automatic logic [XLEN-1:0] f_glue(input logic [XLEN-1:0] b,
                                             input logic [TGT_W-1:0] t);
    return {b[XLEN-1 -: REG_W], t, 2'b00};
  endfunction

  assign target = f_glue(base, tgt);
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  logic [OFS_W-1:0] br_ofs_i,
  input  logic [TGT_W-1:0] jmp_tgt_i,
  input  logic [2:0]       sel_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             link_we_o,
  output logic [XLEN-1:0]  link_val_o
);
  import nextpc_pkg::*;

  npc_sel_e        op;
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  logic            br_taken;
  logic            is_beq, is_bne, is_bal, is_jmp_form, is_link;

  assign op          = npc_sel_e'(sel_i);
  assign is_beq      = (op == NPC_BEQ);
  assign is_bne      = (op == NPC_BNE);
  assign is_bal      = (op == NPC_BAL);
  assign is_jmp_form = (op == NPC_JMP) || (op == NPC_JAL);
  assign is_link     = (op == NPC_JAL) || (op == NPC_BAL);

  npc_incr #(.XLEN(XLEN), .STEP(4)) u_incr (
    .pc          (pc_i),
    .pc_next_seq (pc_plus4)
  );

  npc_branch #(.XLEN(XLEN), .OFS_W(OFS_W)) u_branch (
    .base      (pc_plus4),
    .opa       (rs_val_i),
    .opb       (rt_val_i),
    .ofs       (br_ofs_i),
    .want_eq   (is_beq),
    .want_ne   (is_bne),
    .always_go (is_bal),
    .taken     (br_taken),
    .target    (br_target)
  );

  npc_region #(.XLEN(XLEN), .TGT_W(TGT_W)) u_region (
    .base   (pc_plus4),
    .tgt    (jmp_tgt_i),
    .target (jmp_target)
  );

  always_comb begin
    if (op == NPC_JREG)      next_pc_o = rs_val_i;
    else if (is_jmp_form)    next_pc_o = jmp_target;
    else if (br_taken)       next_pc_o = br_target;
    else                     next_pc_o = pc_plus4;
  end

  assign link_we_o  = is_link;
  assign link_val_o = pc_plus4;
endmodule

// File: rtl/nextpc_chk.sv
module nextpc_chk #(
  parameter int XLEN  = 32,
  parameter int TGT_W = 26
) (
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic [2:0]      sel_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_val_o,
  input logic [XLEN-1:0] pc_plus4,
  input logic            br_taken
);
  localparam int REG_W = XLEN - TGT_W - 2;

  always_comb begin
    if (!$isunknown({pc_i, rs_val_i, rt_val_i, sel_i, next_pc_o, link_we_o})) begin
      if (sel_i == 3'd0 || sel_i == 3'd7)
        p_seq_r1: assert (next_pc_o == pc_i + 4 && !link_we_o);
      if (sel_i == 3'd1 && rs_val_i != rt_val_i)
        p_beq_fall_r2: assert (!br_taken && next_pc_o == pc_plus4);
      if (sel_i == 3'd2 && rs_val_i == rt_val_i)
        p_bne_fall_r3: assert (!br_taken && next_pc_o == pc_plus4);
      if (sel_i == 3'd3 || sel_i == 3'd5)
        p_region_r5: assert (next_pc_o[XLEN-1 -: REG_W] == pc_plus4[XLEN-1 -: REG_W]
                             && next_pc_o[1:0] == 2'b00);
      if (sel_i == 3'd4)
        p_jreg_pass_r6: assert (next_pc_o == rs_val_i);
      if (link_we_o)
        p_link_only_r9: assert (sel_i == 3'd5 || sel_i == 3'd6);
      p_link_val_r9: assert (link_val_o == pc_i + 4);
      if (sel_i == 3'd6)
        p_bal_taken_r8: assert (br_taken && link_we_o);
    end
  end
endmodule

bind nextpc_unit nextpc_chk #(.XLEN(XLEN), .TGT_W(TGT_W)) u_chk (
  .pc_i       (pc_i),
  .rs_val_i   (rs_val_i),
  .rt_val_i   (rt_val_i),
  .sel_i      (sel_i),
  .next_pc_o  (next_pc_o),
  .link_we_o  (link_we_o),
  .link_val_o (link_val_o),
  .pc_plus4   (pc_plus4),
  .br_taken   (br_taken)
);

// File: tb/nextpc_unit_test.sv
module nextpc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc, rs, rt;
  logic [15:0] ofs;
  logic [25:0] tgt;
  logic [2:0]  sel;
  logic [31:0] next_pc, link_val;
  logic        link_we;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] seed = 32'h1357_9bdf;

  always #4 clk = ~clk;

  nextpc_unit uut (
    .pc_i(pc), .rs_val_i(rs), .rt_val_i(rt), .br_ofs_i(ofs),
    .jmp_tgt_i(tgt), .sel_i(sel),
    .next_pc_o(next_pc), .link_we_o(link_we), .link_val_o(link_val)
  );

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sel=%0d pc=%h actual=%h expected=%h", req, sel, pc, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic run_vec(input logic [31:0] p, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] o, input logic [25:0] t);
    for (int s = 0; s < 8; s++) begin
      logic [31:0] seqv, brv, jv, expn;
      logic signed [31:0] so;
      logic expw;
      @(negedge clk);
      pc = p; rs = a; rt = b; ofs = o; tgt = t; sel = 3'(s);
      #1;
      seqv = p + 32'd4;
      so   = 32'(signed'(o));
      brv  = seqv + 32'(so * 4);
      jv   = (seqv & 32'hF000_0000) | ({6'd0, t} * 32'd4);
      expw = 1'b0;
      case (s)
        1: expn = (a == b) ? brv : seqv;
        2: expn = (a != b) ? brv : seqv;
        3: expn = jv;
        4: expn = a;
        5: begin expn = jv; expw = 1'b1; end
        6: begin expn = brv; expw = 1'b1; end
        default: expn = seqv;
      endcase
      check(tag_of(3'(s)), next_pc, expn);
      check("R9 link_we", {31'd0, link_we}, {31'd0, expw});
      check("R9 link_val", link_val, seqv);
      if (p[1:0] == 2'b00 && s != 4)
        check("R10 low bits", {30'd0, next_pc[1:0]}, 32'd0);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pc = '0; rs = '0; rt = '0; ofs = '0; tgt = '0; sel = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 initial", next_pc, 32'd4);
    // R4 corner offsets and wrap
    run_vec(32'h0000_1000, 32'd5, 32'd5, 16'h8000, 26'h3FF_FFFF);
    run_vec(32'h0000_1000, 32'd5, 32'd6, 16'h7FFF, 26'h000_0000);
    run_vec(32'hFFFF_FFFC, 32'd9, 32'd9, 16'h0001, 26'h123_4567);
    run_vec(32'h0000_0000, 32'd1, 32'd1, 16'hFFFF, 26'h000_0001);
    // R5 region edge: region bits come from pc+4
    run_vec(32'h0FFF_FFFC, 32'h8000_0003, 32'h8000_0003, 16'h0004, 26'h2AA_AAAA);
    // R6 unaligned register target
    run_vec(32'h4000_0020, 32'hDEAD_BEEF, 32'hDEAD_BEE0, 16'hFFFE, 26'h155_5555);
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a, b;
      a = rnd();
      b = (i % 3 == 0) ? a : rnd();
      run_vec(rnd() & ((i % 8 == 7) ? 32'hFFFF_FFFF : 32'hFFFF_FFFC), a, b,
              16'(rnd()), 26'(rnd()));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule